// File: doc/BRIEF.md
# Multithreaded Stream Issue Scheduler

This block chooses, on every clock, which hardware instruction stream of a barrel-style multithreaded processor sends its next instruction into the shared execution pipeline. It keeps a small record for each stream: an active bit, a pipeline-occupancy countdown and a count of memory references in flight. It also keeps one processor-wide count of memory references in flight. A stream may issue when it is active, when its previous instruction has left the pipeline, and, if its next instruction touches memory, when neither its own reference budget nor the processor-wide budget is used up.

Each stream's instruction fetch supplies a per-stream flag, `want_mem_i`, that marks the next instruction as a memory operation (load, store or atomic fetch-and-add) rather than an arithmetic one. Among the eligible streams the block grants one in round-robin order, beginning after the last stream granted. The memory system returns a completion with a stream number, and that completion releases one reference from both budgets. Long memory latency is hidden only when enough streams are active to keep an eligible candidate available on most cycles.

Top module: `stream_issue_sched`

## Requirements
- R1: While reset is asserted and on the first clock after it is released, `issue_valid_o`, `issue_id_o` and `issue_mem_o` are all 0. All streams start inactive with zero counts.
- R2: The issue outputs are registered. A selection made from the state and inputs of cycle t appears on the outputs in cycle t+1, and at most one stream is granted per cycle.
- R3: A granted stream stays ineligible for the next PIPE_DEPTH-1 cycles. It becomes eligible again PIPE_DEPTH cycles after its grant. With PIPE_DEPTH=4, a lone active stream issues every fourth cycle.
- R4: A stream with PER_MAX references in flight is not granted while its `want_mem_i` bit is 1. It can still be granted while that bit is 0.
- R5: While the processor-wide count equals GLOB_MAX, no stream with `want_mem_i` at 1 is granted. The count never exceeds GLOB_MAX.
- R6: The grant goes to the first eligible stream in the order last+1, last+2, … wrapping modulo N, where last is the most recently granted stream. After reset, last is N-1, so stream 0 has first priority.
- R7: A completion with `cmpl_valid_i`=1 decrements that stream's count and the processor-wide count by one. In a cycle with both a memory grant and a completion, the two changes net out. A completion naming a stream whose count is 0 has no effect.
- R8: `act_valid_i` sets the active bit of `act_id_i` and `deact_valid_i` clears the active bit of `deact_id_i`. Both take effect for selection from the next cycle. If both name the same stream in one cycle, clear wins. An inactive stream keeps its reference count, which drains through completions and carries over when the stream is activated again.
- R9: In a cycle where no stream is eligible, `issue_valid_o` is 0 in the following cycle (a bubble), and `issue_id_o` and `issue_mem_o` are 0.
- R10: `issue_mem_o` equals the `want_mem_i` bit of the granted stream in the selection cycle. Only such memory grants add to the reference counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid_i | input | 1 | Activate the stream in `act_id_i` |
| act_id_i | input | $clog2(N) | Stream to activate |
| deact_valid_i | input | 1 | Deactivate the stream in `deact_id_i` |
| deact_id_i | input | $clog2(N) | Stream to deactivate |
| want_mem_i | input | N | Per stream: next instruction is a memory operation |
| cmpl_valid_i | input | 1 | A memory reference has completed |
| cmpl_id_i | input | $clog2(N) | Stream owning the completed reference |
| issue_valid_o | output | 1 | An instruction is issued this cycle |
| issue_id_o | output | $clog2(N) | Stream that issues |
| issue_mem_o | output | 1 | The issued instruction is a memory operation |

## Verification
The scheduler is run with a small configuration (16 streams, budgets of 8 and 32) so that both limits are reachable. A lone stream issuing only memory operations with no completions separates the pipeline cadence from the per-stream cap. Eight streams issuing only memory operations reach the processor-wide cap first, which shows whether that budget is enforced apart from the per-stream one. Directed activate/deactivate sequences, including both commands on one stream in one cycle and draining while inactive, exercise the active-bit rules. A long random mix of activations, memory flags and completions, including completions for idle streams and completions in the same cycle as a grant, is compared cycle by cycle against a bench model of the round-robin order and both budgets.

// File: rtl/sis_pkg.sv
package sis_pkg;

    // width of a counter that must hold values 0..max
    function automatic int cnt_w(input int max);
        return (max < 1) ? 1 : $clog2(max + 1);
    endfunction

    // width of the pipeline-occupancy countdown
    function automatic int busy_w(input int depth);
        return (depth <= 2) ? 1 : $clog2(depth);
    endfunction

    typedef enum logic {
        KIND_ALU = 1'b0,
        KIND_MEM = 1'b1
    } issue_kind_e;

endpackage

// File: rtl/sis_slot.sv
module sis_slot #(
    parameter int PER_MAX    = 8,
    parameter int PIPE_DEPTH = 4,
    localparam int PCW = sis_pkg::cnt_w(PER_MAX),
    localparam int BW  = sis_pkg::busy_w(PIPE_DEPTH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           act_set_i,
    input  logic           act_clr_i,
    input  logic           grant_i,
    input  logic           want_mem_i,
    input  logic           cmpl_i,
    input  logic           glob_room_i,
    output logic           ready_o,
    output logic [PCW-1:0] cnt_o
);

    typedef struct packed {
        logic           active;
        logic [BW-1:0]  busy;
        logic [PCW-1:0] cnt;
    } slot_st_t;

    slot_st_t st_q, st_d;
    sis_pkg::issue_kind_e kind;
    logic mem_ok;
    logic inc, dec;

    always_comb begin
        kind   = want_mem_i ? sis_pkg::KIND_MEM : sis_pkg::KIND_ALU;
        mem_ok = (st_q.cnt < PCW'(PER_MAX)) && glob_room_i;
        ready_o = st_q.active && (st_q.busy == '0) &&
                  ((kind == sis_pkg::KIND_ALU) || mem_ok);
        inc = grant_i && (kind == sis_pkg::KIND_MEM);
        dec = cmpl_i && (st_q.cnt != '0);

        st_d = st_q;
        if (st_q.busy != '0)
            st_d.busy = st_q.busy - BW'(1);
        if (grant_i)
            st_d.busy = BW'(PIPE_DEPTH - 1);
        if (act_set_i)
            st_d.active = 1'b1;
        if (act_clr_i)
            st_d.active = 1'b0;
        st_d.cnt = st_q.cnt + {{(PCW-1){1'b0}}, inc} - {{(PCW-1){1'b0}}, dec};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/sis_rr_pick.sv
module sis_rr_pick #(
    parameter int N = 128,
    localparam int SW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    input  logic [SW-1:0] last_i,
    output logic          gnt_valid_o,
    output logic [SW-1:0] gnt_id_o
);

    always_comb begin
        gnt_valid_o = 1'b0;
        gnt_id_o    = '0;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(last_i) + k) % N;
            if (!gnt_valid_o && req_i[idx]) begin
                gnt_valid_o = 1'b1;
                gnt_id_o    = SW'(idx);
            end
        end
    end

endmodule

// File: rtl/stream_issue_sched.sv
module stream_issue_sched #(
    parameter int N          = 128,
    parameter int PER_MAX    = 8,
    parameter int GLOB_MAX   = 1024,
    parameter int PIPE_DEPTH = 4,
    localparam int SW  = (N > 1) ? $clog2(N) : 1,
    localparam int PCW = sis_pkg::cnt_w(PER_MAX),
    localparam int GCW = sis_pkg::cnt_w(GLOB_MAX)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_valid_i,
    input  logic [SW-1:0] act_id_i,
    input  logic          deact_valid_i,
    input  logic [SW-1:0] deact_id_i,
    input  logic [N-1:0]  want_mem_i,
    input  logic          cmpl_valid_i,
    input  logic [SW-1:0] cmpl_id_i,
    output logic          issue_valid_o,
    output logic [SW-1:0] issue_id_o,
    output logic          issue_mem_o
);

    typedef struct packed {
        logic           vld;
        logic [SW-1:0]  id;
        logic           mem;
        logic [SW-1:0]  last;
        logic [GCW-1:0] total;
    } top_st_t;

    top_st_t st_q, st_d;

    logic [N-1:0]          ready_vec;
    logic [N-1:0][PCW-1:0] cnt_vec;
    logic                  any_ready;
    logic                  sel_valid;
    logic [SW-1:0]         sel_id;
    logic                  glob_room;
    logic [GCW-1:0]        total_q;
    logic                  g_inc, g_dec;

    assign glob_room = st_q.total < GCW'(GLOB_MAX);
    assign total_q   = st_q.total;

    for (genvar i = 0; i < N; i++) begin : g_slot
        sis_slot #(
            .PER_MAX   (PER_MAX),
            .PIPE_DEPTH(PIPE_DEPTH)
        ) slot_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .act_set_i  (act_valid_i && (act_id_i == SW'(i))),
            .act_clr_i  (deact_valid_i && (deact_id_i == SW'(i))),
            .grant_i    (sel_valid && (sel_id == SW'(i))),
            .want_mem_i (want_mem_i[i]),
            .cmpl_i     (cmpl_valid_i && (cmpl_id_i == SW'(i))),
            .glob_room_i(glob_room),
            .ready_o    (ready_vec[i]),
            .cnt_o      (cnt_vec[i])
        );
    end

    assign any_ready = |ready_vec;

    sis_rr_pick #(.N(N)) pick_i (
        .req_i      (ready_vec),
        .last_i     (st_q.last),
        .gnt_valid_o(sel_valid),
        .gnt_id_o   (sel_id)
    );

    always_comb begin
        g_inc = sel_valid && want_mem_i[sel_id];
        g_dec = cmpl_valid_i && (cnt_vec[cmpl_id_i] != '0);

        st_d       = st_q;
        st_d.vld   = sel_valid;
        st_d.id    = sel_valid ? sel_id : '0;
        st_d.mem   = g_inc;
        if (sel_valid)
            st_d.last = sel_id;
        st_d.total = st_q.total + {{(GCW-1){1'b0}}, g_inc} - {{(GCW-1){1'b0}}, g_dec};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.last <= SW'(N - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign issue_valid_o = st_q.vld;
    assign issue_id_o    = st_q.id;
    assign issue_mem_o   = st_q.mem;

endmodule

// File: rtl/sis_checker.sv
module sis_checker #(
    parameter int N        = 128,
    parameter int PER_MAX  = 8,
    parameter int GLOB_MAX = 1024,
    localparam int SW  = (N > 1) ? $clog2(N) : 1,
    localparam int PCW = sis_pkg::cnt_w(PER_MAX),
    localparam int GCW = sis_pkg::cnt_w(GLOB_MAX)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  any_ready,
    input logic [GCW-1:0]        total_q,
    input logic [N-1:0][PCW-1:0] cnt_vec,
    input logic                  issue_valid_o,
    input logic [SW-1:0]         issue_id_o,
    input logic                  issue_mem_o
);

    // R5: processor-wide count bounded
    p_glob_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        total_q <= GCW'(GLOB_MAX));

    // R5: a memory grant only leaves room below the global budget
    p_mem_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid_o && issue_mem_o |-> $past(total_q) < GCW'(GLOB_MAX));

    // R4: every stream count bounded
    for (genvar i = 0; i < N; i++) begin : g_cap
        p_stream_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_vec[i] <= PCW'(PER_MAX));
    end

    // R2: an eligible stream always leads to a grant next cycle
    p_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
        any_ready |=> issue_valid_o);

    // R9: nothing eligible gives a bubble
    p_bubble_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !any_ready |=> !issue_valid_o && issue_id_o == '0 && !issue_mem_o);

    // R7: the global count moves by at most one per cycle
    p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (total_q == $past(total_q)) ||
                 (total_q == $past(total_q) + GCW'(1)) ||
                 (total_q + GCW'(1) == $past(total_q)));

    // R10: memory flag only with a valid grant
    p_mem_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        issue_mem_o |-> issue_valid_o);

endmodule

bind stream_issue_sched sis_checker #(
    .N       (N),
    .PER_MAX (PER_MAX),
    .GLOB_MAX(GLOB_MAX)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .any_ready    (any_ready),
    .total_q      (total_q),
    .cnt_vec      (cnt_vec),
    .issue_valid_o(issue_valid_o),
    .issue_id_o   (issue_id_o),
    .issue_mem_o  (issue_mem_o)
);

// File: tb/stream_issue_sched_tb.sv
module stream_issue_sched_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NS   = 16;
    localparam int PM   = 8;
    localparam int GM   = 32;
    localparam int PD   = 4;
    localparam int SW   = $clog2(NS);
    localparam int WDOG = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          act_valid_i = 1'b0;
    logic [SW-1:0] act_id_i = '0;
    logic          deact_valid_i = 1'b0;
    logic [SW-1:0] deact_id_i = '0;
    logic [NS-1:0] want_mem_i = '0;
    logic          cmpl_valid_i = 1'b0;
    logic [SW-1:0] cmpl_id_i = '0;
    logic          issue_valid_o;
    logic [SW-1:0] issue_id_o;
    logic          issue_mem_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    stream_issue_sched #(
        .N(NS), .PER_MAX(PM), .GLOB_MAX(GM), .PIPE_DEPTH(PD)
    ) dut_i (.*);

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // bench model
    bit m_act [NS];
    int m_busy[NS];
    int m_cnt [NS];
    int m_total;
    int m_last;
    bit e_vld;
    int e_id;
    bit e_mem;
    int mem_grants;

    function automatic bit elig(input int s);
        if (!m_act[s] || m_busy[s] != 0) return 0;
        if (!want_mem_i[s]) return 1;
        return (m_cnt[s] < PM) && (m_total < GM);
    endfunction

    task automatic model_step();
        bit dec;
        e_vld = 0; e_id = 0; e_mem = 0;
        for (int k = 1; k <= NS; k++) begin
            int s = (m_last + k) % NS;
            if (!e_vld && elig(s)) begin
                e_vld = 1; e_id = s;
            end
        end
        if (e_vld) e_mem = want_mem_i[e_id];
        dec = cmpl_valid_i && (m_cnt[cmpl_id_i] != 0);
        for (int s = 0; s < NS; s++)
            if (m_busy[s] > 0) m_busy[s]--;
        if (e_vld) begin
            m_busy[e_id] = PD - 1;
            m_last = e_id;
            if (e_mem) begin
                m_cnt[e_id]++; m_total++; mem_grants++;
            end
        end
        if (dec) begin
            m_cnt[cmpl_id_i]--; m_total--;
        end
        if (act_valid_i) m_act[act_id_i] = 1;
        if (deact_valid_i) m_act[deact_id_i] = 0;
    endtask

    task automatic check(input string req, input bit ok,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(input string req);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check({req, " valid"}, issue_valid_o == e_vld, issue_valid_o, e_vld);
        check({req, " id"}, int'(issue_id_o) == e_id, issue_id_o, e_id);
        check({req, " mem"}, issue_mem_o == e_mem, issue_mem_o, e_mem);
        act_valid_i = 0; deact_valid_i = 0; cmpl_valid_i = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        act_valid_i = 0; deact_valid_i = 0; cmpl_valid_i = 0; want_mem_i = '0;
        for (int s = 0; s < NS; s++) begin
            m_act[s] = 0; m_busy[s] = 0; m_cnt[s] = 0;
        end
        m_total = 0; m_last = NS - 1; mem_grants = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset valid", issue_valid_o == 0, issue_valid_o, 0);
        check("R1 reset id", issue_id_o == 0, issue_id_o, 0);
        rst_n = 1;
        cyc("R1 first cycle");
    endtask

    task automatic activate(input int s, input string req);
        act_valid_i = 1; act_id_i = SW'(s);
        cyc(req);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", WDOG, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        do_reset();

        // R9: bubbles with nothing active
        repeat (4) cyc("R9 idle bubble");

        // R3/R6: lone stream cadence, then round robin over three
        activate(5, "R8 activate");
        repeat (12) cyc("R3 lone cadence");
        activate(2, "R8 activate");
        activate(9, "R8 activate");
        repeat (20) cyc("R6 rotation");

        // R4: per-stream cap with memory-only stream
        do_reset();
        want_mem_i = '1;
        activate(3, "R4 activate");
        repeat (50) cyc("R4 cap stall");
        check("R4 mem grants", mem_grants == PM, mem_grants, PM);
        want_mem_i = '0;
        repeat (8) cyc("R4 alu passes cap");

        // R5: global cap with eight streams
        do_reset();
        want_mem_i = '1;
        for (int s = 0; s < 8; s++) activate(s, "R5 activate");
        repeat (60) cyc("R5 global stall");
        check("R5 mem grants", mem_grants == GM, mem_grants, GM);
        // R7: one completion frees one slot, same-cycle grant nets
        cmpl_valid_i = 1; cmpl_id_i = 3;
        cyc("R7 completion");
        repeat (6) cyc("R7 refill");
        check("R7 total after refill", m_total == GM, m_total, GM);
        cmpl_valid_i = 1; cmpl_id_i = 12;
        cyc("R7 zero-count completion ignored");
        repeat (4) cyc("R7 still capped");

        // R8: clear wins, drain while inactive, carry over
        do_reset();
        act_valid_i = 1; act_id_i = 6; deact_valid_i = 1; deact_id_i = 6;
        cyc("R8 clear wins");
        repeat (6) cyc("R8 clear wins idle");
        want_mem_i = '1;
        activate(2, "R8 activate");
        repeat (40) cyc("R8 fill");
        deact_valid_i = 1; deact_id_i = 2;
        cyc("R8 deactivate");
        for (int k = 0; k < 4; k++) begin
            cmpl_valid_i = 1; cmpl_id_i = 2;
            cyc("R8 drain inactive");
        end
        repeat (4) cyc("R8 inactive no issue");
        activate(2, "R8 reactivate");
        repeat (30) cyc("R8 carry over");

        // random mix, R2 R6 R7 R10
        do_reset();
        for (int t = 0; t < 4000; t++) begin
            if ($urandom_range(7) == 0) begin
                act_valid_i = 1; act_id_i = SW'($urandom_range(NS-1));
            end
            if ($urandom_range(15) == 0) begin
                deact_valid_i = 1; deact_id_i = SW'($urandom_range(NS-1));
            end
            want_mem_i = NS'($urandom) & NS'($urandom);
            if ($urandom_range(3) != 0) begin
                int s = $urandom_range(NS-1);
                cmpl_valid_i = 1;
                cmpl_id_i = SW'(s);
                for (int k = 0; k < NS; k++)
                    if (m_cnt[(s + k) % NS] != 0 && m_cnt[s] == 0 && $urandom_range(7) != 0)
                        s = (s + k) % NS;
                cmpl_id_i = SW'(s);
            end
            cyc("R2 R6 R7 R10 random");
        end

        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule